// File: doc/BRIEF.md
# Interrupt Cause Priority Arbiter

This block sits beside an instruction sequencer. At each instruction boundary it looks at every reason the processor might have to leave its current program and picks one. The candidates are an internal arithmetic fault, a software interrupt instruction carrying its own 8-bit type, a conditional overflow trap, a non-maskable request pin, a maskable request pin, and the single-step condition. The interrupt-enable and trap flags also feed the decision. The result is a one-cycle take pulse and an 8-bit type number. When the winner is the maskable pin, the block raises a flag saying that the type must come from an external acknowledge cycle, and it does not generate a type of its own.

The sequencer marks each completed instruction with a one-cycle `instrDone` strobe. The arithmetic, software and overflow strobes describe that same instruction, so they count only in the boundary cycle. The non-maskable pin is detected on its rising edge and held until it is serviced, so one assertion yields exactly one service. The maskable pin is level-sensitive and is sampled only at a boundary.

Top module: `int_cause_arbiter`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, takeIrq, irqType and extVector are all 0.
- R2: Causes are evaluated only in a cycle where instrDone is 1. The decision is registered, so takeIrq is high for exactly the one cycle that follows that boundary. No take ever follows a cycle in which instrDone is 0.
- R3: An arithmetic fault (arithErr) at a boundary gives type 0 with extVector 0. Among the instruction-related causes, the arithmetic fault beats the software interrupt, and the software interrupt beats the overflow trap.
- R4: A software interrupt (swIntValid) gives the type presented on swIntType, for example 3 for a breakpoint.
- R5: An overflow trap (ovfTrap) gives type 4 only when ovfFlag is 1. When ovfFlag is 0 the trap contributes nothing.
- R6: Instruction-related causes win over the non-maskable request. A request that loses in this way stays pending and is serviced at a later boundary.
- R7: A rising edge on nmiPin is latched, even when it arrives between boundaries. It gives type 2 exactly once, whatever the value of ieFlag, and a pin that stays high does not cause a second service.
- R8: intrPin is accepted only when ieFlag is 1. It sets extVector to 1 and leaves irqType at its previous value.
- R9: intrPin is refused at a boundary where a non-maskable request is pending or rising. The non-maskable request is serviced instead.
- R10: When tfFlag is 1 and no other cause is present, a boundary gives type 1. Single-step has the lowest priority.
- R11: A boundary with no cause leaves takeIrq low, and irqType and extVector keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instrDone | input | 1 | Instruction-boundary strobe |
| arithErr | input | 1 | Arithmetic fault from the completing instruction |
| swIntValid | input | 1 | Software interrupt instruction completed |
| swIntType | input | 8 | Type carried by the software interrupt |
| ovfTrap | input | 1 | Conditional overflow-trap instruction completed |
| ovfFlag | input | 1 | Current overflow flag |
| nmiPin | input | 1 | Non-maskable request, detected on its rising edge |
| intrPin | input | 1 | Maskable request, level-sensitive |
| ieFlag | input | 1 | Interrupt-enable flag |
| tfFlag | input | 1 | Trap (single-step) flag |
| takeIrq | output | 1 | One-cycle pulse: take an interrupt |
| irqType | output | 8 | Selected type number |
| extVector | output | 1 | Type must be fetched by an external acknowledge |

## Verification
Every result is due exactly one clock after the boundary that produced it, because the decision passes through a single register stage. The driver applies the boundary inputs on a falling edge and queues the expected item at that moment. The monitor compares one nanosecond after the next rising edge, and it expects no take at all when nothing was queued. Non-maskable edges are driven on their own cycles between boundaries, so that the latch has to carry them forward to a later decision.

// File: rtl/int_arb_pkg.sv
package int_arb_pkg;
  typedef enum logic [2:0] {
    SEL_NONE, SEL_ARITH, SEL_SOFT, SEL_OVF, SEL_NMI, SEL_INTR, SEL_STEP
  } causeSel_e;

  // control -> datapath strobes
  typedef struct packed {
    logic      fire;
    logic      extSel;
    causeSel_e sel;
  } arbStrobe_t;
endpackage

// File: rtl/int_arb_nmi_latch.sv
module int_arb_nmi_latch (
  input  logic clk,
  input  logic rstN,
  input  logic nmiPin,
  input  logic consume,
  output logic nmiActive
);
  logic nmiPrev;
  logic nmiPend;
  logic nmiRise;

  assign nmiRise   = nmiPin & ~nmiPrev;
  assign nmiActive = nmiPend | nmiRise;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nmiPrev <= 1'b0;
      nmiPend <= 1'b0;
    end else begin
      nmiPrev <= nmiPin;
      nmiPend <= nmiActive & ~consume;
    end
  end
endmodule

// File: rtl/int_arb_ctrl.sv
module int_arb_ctrl
  import int_arb_pkg::*;
(
  input  logic       instrDone,
  input  logic       arithErr,
  input  logic       swIntValid,
  input  logic       ovfTrap,
  input  logic       ovfFlag,
  input  logic       nmiActive,
  input  logic       intrPin,
  input  logic       ieFlag,
  input  logic       tfFlag,
  output arbStrobe_t strb,
  output logic       nmiConsume
);
  causeSel_e pick;

  always_comb begin
    if (arithErr)                 pick = SEL_ARITH;
    else if (swIntValid)          pick = SEL_SOFT;
    else if (ovfTrap && ovfFlag)  pick = SEL_OVF;
    else if (nmiActive)           pick = SEL_NMI;
    else if (intrPin && ieFlag)   pick = SEL_INTR;
    else if (tfFlag)              pick = SEL_STEP;
    else                          pick = SEL_NONE;
  end

  always_comb begin
    strb.sel    = instrDone ? pick : SEL_NONE;
    strb.fire   = instrDone && (pick != SEL_NONE);
    strb.extSel = instrDone && (pick == SEL_INTR);
    nmiConsume  = instrDone && (pick == SEL_NMI);
  end
endmodule

// File: rtl/int_arb_dp.sv
module int_arb_dp
  import int_arb_pkg::*;
#(
  parameter int TYPE_W     = 8,
  parameter int ARITH_TYPE = 0,
  parameter int STEP_TYPE  = 1,
  parameter int NMI_TYPE   = 2,
  parameter int OVF_TYPE   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  arbStrobe_t        strb,
  input  logic [TYPE_W-1:0] swIntType,
  output logic              takeIrq,
  output logic [TYPE_W-1:0] irqType,
  output logic              extVector
);
  logic [TYPE_W-1:0] typeMux;

  always_comb begin
    case (strb.sel)
      SEL_ARITH: typeMux = TYPE_W'(ARITH_TYPE);
      SEL_SOFT:  typeMux = swIntType;
      SEL_OVF:   typeMux = TYPE_W'(OVF_TYPE);
      SEL_NMI:   typeMux = TYPE_W'(NMI_TYPE);
      SEL_STEP:  typeMux = TYPE_W'(STEP_TYPE);
      default:   typeMux = irqType;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      takeIrq   <= 1'b0;
      irqType   <= '0;
      extVector <= 1'b0;
    end else begin
      takeIrq <= strb.fire;
      if (strb.fire) begin
        extVector <= strb.extSel;
        irqType   <= typeMux;
      end
    end
  end
endmodule

// File: rtl/int_cause_arbiter.sv
module int_cause_arbiter
  import int_arb_pkg::*;
#(
  parameter int TYPE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instrDone,
  input  logic              arithErr,
  input  logic              swIntValid,
  input  logic [TYPE_W-1:0] swIntType,
  input  logic              ovfTrap,
  input  logic              ovfFlag,
  input  logic              nmiPin,
  input  logic              intrPin,
  input  logic              ieFlag,
  input  logic              tfFlag,
  output logic              takeIrq,
  output logic [TYPE_W-1:0] irqType,
  output logic              extVector
);
  arbStrobe_t strb;
  logic       nmiActive;
  logic       nmiConsume;

  int_arb_nmi_latch u_nmi (
    .clk(clk), .rstN(rstN), .nmiPin(nmiPin),
    .consume(nmiConsume), .nmiActive(nmiActive)
  );

  int_arb_ctrl u_ctrl (
    .instrDone(instrDone), .arithErr(arithErr), .swIntValid(swIntValid),
    .ovfTrap(ovfTrap), .ovfFlag(ovfFlag), .nmiActive(nmiActive),
    .intrPin(intrPin), .ieFlag(ieFlag), .tfFlag(tfFlag),
    .strb(strb), .nmiConsume(nmiConsume)
  );

  int_arb_dp #(.TYPE_W(TYPE_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .swIntType(swIntType),
    .takeIrq(takeIrq), .irqType(irqType), .extVector(extVector)
  );
endmodule

// File: rtl/int_cause_arbiter_chk.sv
module int_cause_arbiter_chk #(
  parameter int TYPE_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              instrDone,
  input logic              arithErr,
  input logic              swIntValid,
  input logic              ovfTrap,
  input logic              ovfFlag,
  input logic              ieFlag,
  input logic              takeIrq,
  input logic [TYPE_W-1:0] irqType,
  input logic              extVector
);
  // R2
  take_needs_boundary_chk: assert property (@(posedge clk) disable iff (!rstN)
    takeIrq |-> $past(instrDone));

  // R3
  arith_type_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(instrDone && arithErr) |-> (takeIrq && irqType == '0 && !extVector));

  // R5
  ovf_type_four_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(instrDone && ovfTrap && ovfFlag && !arithErr && !swIntValid)
      |-> (takeIrq && irqType == TYPE_W'(4)));

  // R8
  intr_needs_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (takeIrq && extVector) |-> $past(ieFlag));

  // R8
  intr_type_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (takeIrq && extVector) |-> $stable(irqType));

  // R11
  idle_type_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !takeIrq |-> ($stable(irqType) && $stable(extVector)));
endmodule

bind int_cause_arbiter int_cause_arbiter_chk #(.TYPE_W(TYPE_W)) u_chk (
  .clk(clk), .rstN(rstN), .instrDone(instrDone), .arithErr(arithErr),
  .swIntValid(swIntValid), .ovfTrap(ovfTrap), .ovfFlag(ovfFlag),
  .ieFlag(ieFlag), .takeIrq(takeIrq), .irqType(irqType), .extVector(extVector)
);

// File: tb/int_cause_arbiter_tb_top.sv
`timescale 1ns/1ps
module int_cause_arbiter_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       instrDone = 1'b0, arithErr = 1'b0, swIntValid = 1'b0;
  logic [7:0] swIntType = 8'h00;
  logic       ovfTrap = 1'b0, ovfFlag = 1'b0, nmiPin = 1'b0, intrPin = 1'b0;
  logic       ieFlag = 1'b0, tfFlag = 1'b0;
  logic       takeIrq, extVector;
  logic [7:0] irqType;

  always #10 clk = ~clk;

  int_cause_arbiter dut_i (
    .clk(clk), .rstN(rstN), .instrDone(instrDone), .arithErr(arithErr),
    .swIntValid(swIntValid), .swIntType(swIntType), .ovfTrap(ovfTrap),
    .ovfFlag(ovfFlag), .nmiPin(nmiPin), .intrPin(intrPin), .ieFlag(ieFlag),
    .tfFlag(tfFlag), .takeIrq(takeIrq), .irqType(irqType), .extVector(extVector)
  );

  typedef struct packed {
    logic       take;
    logic [7:0] typ;
    logic       ext;
    logic [7:0] req;
  } expItem_t;

  expItem_t expQ[$];
  int compared = 0, mismatched = 0;
  logic       modelPend = 1'b0, modelPrev = 1'b0;
  logic [7:0] lastType = 8'h00;
  logic       lastExt = 1'b0;
  bit         monOn = 1'b0;

  task automatic check(input bit ok, input string req, input string act, input string exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%s expected=%s", req, act, exp);
    end
  endtask

  // change pins on an idle cycle; model tracks edges
  task automatic setPins(input logic nmi, input logic intr);
    @(negedge clk);
    if (nmi && !modelPrev) modelPend = 1'b1;
    modelPrev = nmi;
    nmiPin = nmi;
    intrPin = intr;
  endtask

  // one boundary cycle, expected result queued
  task automatic boundary(input logic ae, input logic sw, input logic [7:0] swT,
                          input logic ov, input logic of, input logic ie,
                          input logic tf, input logic [7:0] req);
    expItem_t e;
    logic nmiAct;
    @(negedge clk);
    instrDone = 1; arithErr = ae; swIntValid = sw; swIntType = swT;
    ovfTrap = ov; ovfFlag = of; ieFlag = ie; tfFlag = tf;
    nmiAct = modelPend;
    e.take = 1'b1; e.ext = 1'b0; e.typ = lastType; e.req = req;
    if (ae)                   e.typ = 8'd0;
    else if (sw)              e.typ = swT;
    else if (ov && of)        e.typ = 8'd4;
    else if (nmiAct) begin    e.typ = 8'd2; modelPend = 1'b0; end
    else if (intrPin && ie)   e.ext = 1'b1;
    else if (tf)              e.typ = 8'd1;
    else begin                e.take = 1'b0; e.ext = lastExt; end
    if (e.take) begin lastType = e.typ; lastExt = e.ext; end
    expQ.push_back(e);
    @(negedge clk);
    instrDone = 0; arithErr = 0; swIntValid = 0; ovfTrap = 0;
  endtask

  // monitor: compare one ns after each rising edge
  always @(posedge clk) begin
    #1;
    if (monOn) begin
      if (expQ.size() > 0) begin
        expItem_t e;
        e = expQ.pop_front();
        check(takeIrq == e.take && extVector == e.ext && irqType == e.typ,
              $sformatf("R%0d", e.req),
              $sformatf("take=%0b type=%0h ext=%0b", takeIrq, irqType, extVector),
              $sformatf("take=%0b type=%0h ext=%0b", e.take, e.typ, e.ext));
      end else if (takeIrq) begin
        check(1'b0, "R2 idle", "take=1", "take=0");
      end
    end
  end

  initial begin
    #4_000_000;
    check(1'b0, "watchdog", "timeout", "finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 in reset
    check(takeIrq == 0 && irqType == 0 && extVector == 0, "R1",
          $sformatf("%0b/%0h/%0b", takeIrq, irqType, extVector), "0/0/0");
    rstN = 1'b1;
    @(negedge clk);
    check(takeIrq == 0 && irqType == 0 && extVector == 0, "R1",
          $sformatf("%0b/%0h/%0b", takeIrq, irqType, extVector), "0/0/0");
    monOn = 1'b1;

    boundary(0,0,8'h00,0,0,0,1, 8'd10);        // R10 single-step
    boundary(0,0,8'h00,0,0,0,0, 8'd11);        // R11 nothing
    boundary(1,0,8'h00,0,0,0,0, 8'd3);         // R3 arith
    boundary(0,1,8'h21,0,0,0,0, 8'd4);         // R4 software 0x21
    boundary(0,1,8'h03,0,0,0,0, 8'd4);         // R4 breakpoint
    boundary(0,0,8'h00,1,1,0,0, 8'd5);         // R5 overflow taken
    boundary(0,0,8'h00,1,0,0,0, 8'd5);         // R5 overflow not set
    boundary(1,1,8'h40,1,1,0,0, 8'd3);         // R3 arith beats all
    boundary(0,1,8'h40,1,1,0,0, 8'd3);         // R3 sw beats ovf

    // R2: strobe without boundary
    @(negedge clk); arithErr = 1; swIntValid = 1;
    @(negedge clk); arithErr = 0; swIntValid = 0;
    @(negedge clk);

    setPins(1, 1);                             // nmi rise, intr high
    boundary(0,0,8'h00,0,0,1,0, 8'd9);         // R9 nmi wins
    boundary(0,0,8'h00,0,0,1,0, 8'd7);         // R7 held pin: intr now
    boundary(0,0,8'h00,0,0,0,0, 8'd8);         // R8 ie=0 refused
    setPins(0, 0);
    boundary(1,0,8'h00,0,0,0,1, 8'd3);         // type back to 0
    setPins(1, 0);                             // edge between boundaries
    setPins(0, 0);
    boundary(0,1,8'h55,0,0,0,0, 8'd6);         // R6 sw beats pending nmi
    boundary(0,0,8'h00,0,0,0,0, 8'd6);         // R6 nmi later, ie=0 (R7)
    boundary(0,0,8'h00,0,0,0,0, 8'd7);         // R7 only once
    setPins(0, 1);
    boundary(0,0,8'h00,0,0,1,1, 8'd10);        // R10 intr beats step
    setPins(1, 0);
    boundary(0,0,8'h00,0,0,0,1, 8'd10);        // R10 nmi beats step
    boundary(0,0,8'h00,0,0,0,1, 8'd10);        // step again

    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule